// File: doc/BRIEF.md
# Dual Gated Timer/Counter

This block contains two identical 16-bit timer/counter channels behind a small byte-wide register port. Each channel advances either on an internal machine-cycle tick or on falling edges of its own external count input. Counting runs only while the channel's run bit is set. When the channel's gate option is on, it also needs the channel's gate pin to be high. That lets an external signal level measure pulse widths in hardware.

Each channel has four count layouts:
- a 13-bit count made from a 5-bit prescaler and an 8-bit high byte;
- a plain 16-bit count;
- an 8-bit count that reloads from the high byte;
- two free 8-bit counts.

A wrap of the count sets the channel's flag. The flag is presented as a level interrupt request. Software clears it by writing 0, and an acknowledge strobe from the interrupt logic also clears it.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0x00 and both interrupt outputs are low.
- R2: Register map at `reg_addr_i`:
  - 0 = mode byte. Channel c uses bits [4c+3:4c]. Within that nibble, bits [1:0] are the layout, bit 2 selects the external source when 1, and bit 3 is the gate enable.
  - 1 = control byte. Bit 2c is the run bit of channel c and bit 2c+1 is its flag. Bits 7:4 read 0.
  - 2+2c = low count byte of channel c.
  - 3+2c = high count byte of channel c.
  - All other addresses read 0.
  - Reads are combinational. A write takes effect at the next clock edge.
- R3: A channel counts only while its run bit is 1. If its gate bit is 1, it also counts only while its gate pin is high.
- R4: With the source bit at 0, one count is taken per cycle with `tick_i` high. With the source bit at 1, the external input is sampled on tick cycles and one count is taken per high-to-low change between two successive samples. Edges between ticks and tick cycles without an edge take no count.
- R5: Layout 0: the low 5 bits of the low byte count and carry into the high byte. Low-byte bits 7:5 keep their value. Wrapping from high byte 0xFF with prescaler 0x1F gives 0 and sets the flag.
- R6: Layout 1: the 16-bit value counts up. Wrapping from 0xFFFF to 0x0000 sets the flag.
- R7: Layout 2: the low byte counts up. At 0xFF it loads the high byte instead and sets the flag. The high byte does not change.
- R8: Layout 3: the low byte counts under R3 and R4 and sets the flag when it wraps. The high byte counts every tick while the run bit is 1, ignoring gate and source, and also sets the flag when it wraps.
- R9: A flag is cleared by a control write of 0 to it or by a pulse on the channel's `irq_ack_i` bit. An overflow in the same cycle wins over either clear. `irq_o[c]` equals the flag of channel c.
- R10: The two channels count independently of each other's settings and inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Machine-cycle tick enable |
| ext_cnt_i | input | 2 | External count input per channel |
| gate_pin_i | input | 2 | Gate level input per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_ack_i | input | 2 | Interrupt acknowledge per channel |
| irq_o | output | 2 | Interrupt request (flag level) per channel |

## Verification
The following properties are checked on every cycle:
- A count does not move while its run bit is clear, while its gate is closed, with no tick, or while its external input sits high in counter mode.
- A flag can only rise after an overflow or a control write.
- An acknowledge with no overflow clears the flag.
- An overflow always sets the flag.

Only the bench scenarios can show the exact count values:
- the carry from the 5-bit prescaler and the preserved low-byte bits;
- the reload value in layout 2;
- the separate high-byte count in layout 3;
- the exact number of falling edges taken;
- overflow winning over an acknowledge in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        M_PRE13   = 2'd0,
        M_FULL16  = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT8  = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/tmr_evt.sv
module tmr_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic ext_i,
    input  logic gate_pin_i,
    input  logic run_i,
    input  logic gate_en_i,
    input  logic ext_src_i,
    output logic evt_o
);
    typedef struct packed {
        logic prev;
    } evt_st_t;

    evt_st_t st_d, st_q;
    logic    allowed;
    logic    src_evt;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.prev = ext_i;
        end
        allowed = run_i & (~gate_en_i | gate_pin_i);
        src_evt = ext_src_i ? (tick_i & st_q.prev & ~ext_i) : tick_i;
        evt_o   = allowed & src_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_mode_e         mode_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              evt_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic              ovf_o
);
    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [PRE_W-1:0]  PRE_ONE  = 1;
    localparam logic [BYTE_W-1:0] BYTE_ONE = 1;
    localparam logic [WORD_W-1:0] WORD_ONE = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic ovf;

    always_comb begin
        cnt_d = cnt_q;
        ovf   = 1'b0;
        case (mode_i)
            M_PRE13: begin
                if (evt_i) begin
                    if (&cnt_q.lo[PRE_W-1:0]) begin
                        cnt_d.lo[PRE_W-1:0] = '0;
                        cnt_d.hi            = cnt_q.hi + BYTE_ONE;
                        ovf                 = &cnt_q.hi;
                    end else begin
                        cnt_d.lo[PRE_W-1:0] = cnt_q.lo[PRE_W-1:0] + PRE_ONE;
                    end
                end
            end
            M_FULL16: begin
                if (evt_i) begin
                    cnt_d = cnt_t'({cnt_q.hi, cnt_q.lo} + WORD_ONE);
                    ovf   = &{cnt_q.hi, cnt_q.lo};
                end
            end
            M_RELOAD8: begin
                if (evt_i) begin
                    if (&cnt_q.lo) begin
                        cnt_d.lo = cnt_q.hi;
                        ovf      = 1'b1;
                    end else begin
                        cnt_d.lo = cnt_q.lo + BYTE_ONE;
                    end
                end
            end
            default: begin
                if (evt_i) begin
                    cnt_d.lo = cnt_q.lo + BYTE_ONE;
                    ovf      = &cnt_q.lo;
                end
                if (run_i && tick_i) begin
                    cnt_d.hi = cnt_q.hi + BYTE_ONE;
                    ovf      = ovf | (&cnt_q.hi);
                end
            end
        endcase
        if (wr_lo_i) begin
            cnt_d.lo = wdata_i;
        end
        if (wr_hi_i) begin
            cnt_d.hi = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign lo_o  = cnt_q.lo;
    assign hi_o  = cnt_q.hi;
    assign ovf_o = ovf;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NCH-1:0]    ext_cnt_i,
    input  logic [NCH-1:0]    gate_pin_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o,
    input  logic [NCH-1:0]    irq_ack_i,
    output logic [NCH-1:0]    irq_o
);
    localparam int MODE_W    = 4 * NCH;
    localparam int CTRL_W    = 2 * NCH;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int ADDR_MODE = 0;
    localparam int ADDR_CTRL = 1;
    localparam int ADDR_CNT0 = 2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CTRL_W-1:0] ctrl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [MODE_W-1:0]             mode_w;
    logic [NCH-1:0]                run_w;
    logic [NCH-1:0]                ovf_w;
    logic [NCH-1:0]                evt_w;
    logic [NCH-1:0][BYTE_W-1:0]    lo_w;
    logic [NCH-1:0][BYTE_W-1:0]    hi_w;
    logic [NCH-1:0][WORD_W-1:0]    cnt_w;

    assign mode_w = regs_q.mode;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_MODE)) begin
            regs_d.mode = reg_wdata_i[MODE_W-1:0];
        end
        if (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
            regs_d.ctrl = reg_wdata_i[CTRL_W-1:0];
        end
        for (int c = 0; c < NCH; c++) begin
            if (irq_ack_i[c]) begin
                regs_d.ctrl[2*c+1] = 1'b0;
            end
            if (ovf_w[c]) begin
                regs_d.ctrl[2*c+1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADDR_MODE)) begin
            reg_rdata_o[MODE_W-1:0] = regs_q.mode;
        end
        if (reg_addr_i == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata_o[CTRL_W-1:0] = regs_q.ctrl;
        end
        for (int c = 0; c < NCH; c++) begin
            if (reg_addr_i == ADDR_W'(ADDR_CNT0 + 2*c)) begin
                reg_rdata_o = lo_w[c];
            end
            if (reg_addr_i == ADDR_W'(ADDR_CNT0 + 2*c + 1)) begin
                reg_rdata_o = hi_w[c];
            end
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic wr_lo, wr_hi;

        assign run_w[c]  = regs_q.ctrl[2*c];
        assign irq_o[c]  = regs_q.ctrl[2*c+1];
        assign wr_lo     = reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CNT0 + 2*c);
        assign wr_hi     = reg_wr_i && reg_addr_i == ADDR_W'(ADDR_CNT0 + 2*c + 1);
        assign cnt_w[c]  = {hi_w[c], lo_w[c]};

        tmr_evt u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tick_i),
            .ext_i      (ext_cnt_i[c]),
            .gate_pin_i (gate_pin_i[c]),
            .run_i      (run_w[c]),
            .gate_en_i  (mode_w[4*c+3]),
            .ext_src_i  (mode_w[4*c+2]),
            .evt_o      (evt_w[c])
        );

        tmr_chan #(
            .BYTE_W (BYTE_W),
            .PRE_W  (PRE_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_i  (tmr_mode_e'(mode_w[4*c +: 2])),
            .run_i   (run_w[c]),
            .tick_i  (tick_i),
            .evt_i   (evt_w[c]),
            .wr_lo_i (wr_lo),
            .wr_hi_i (wr_hi),
            .wdata_i (reg_wdata_i),
            .lo_o    (lo_w[c]),
            .hi_o    (hi_w[c]),
            .ovf_o   (ovf_w[c])
        );
    end
endmodule

module tmr_pair_chk #(
    parameter int NCH    = 2,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           tick,
    input logic [4*NCH-1:0]               mode_q,
    input logic [NCH-1:0]                 run,
    input logic                           reg_wr,
    input logic [ADDR_W-1:0]              reg_addr,
    input logic [NCH-1:0]                 gate_pin,
    input logic [NCH-1:0]                 ext_cnt,
    input logic [NCH-1:0]                 ack,
    input logic [NCH-1:0]                 ovf,
    input logic [NCH-1:0]                 irq,
    input logic [NCH-1:0][2*BYTE_W-1:0]   cnt
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && reg_addr == ADDR_W'(1);

    for (genvar c = 0; c < NCH; c++) begin : g_c
        logic wr_cnt;
        logic split;
        assign wr_cnt = reg_wr && (reg_addr == ADDR_W'(2 + 2*c) || reg_addr == ADDR_W'(3 + 2*c));
        assign split  = mode_q[4*c +: 2] == 2'd3;

        // R3
        run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[c] && !wr_cnt) |=> $stable(cnt[c]));

        // R3
        gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[4*c+3] && !gate_pin[c] && !split && !wr_cnt) |=> $stable(cnt[c]));

        // R4
        no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tick && !wr_cnt) |=> $stable(cnt[c]));

        // R4
        ext_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[4*c+2] && ext_cnt[c] && !split && !wr_cnt) |=> $stable(cnt[c]));

        // R3
        ovf_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[c] |-> run[c]);

        // R9
        flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> $past(ovf[c] || ctrl_wr));

        // R9
        ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[c] && !ovf[c]) |=> !irq[c]);

        // R9
        ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ovf[c] |=> irq[c]);
    end
endmodule

bind tmr_pair tmr_pair_chk #(
    .NCH    (tmr_pkg::NCH),
    .BYTE_W (BYTE_W),
    .ADDR_W (tmr_pkg::ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .mode_q   (mode_w),
    .run      (run_w),
    .reg_wr   (reg_wr_i),
    .reg_addr (reg_addr_i),
    .gate_pin (gate_pin_i),
    .ext_cnt  (ext_cnt_i),
    .ack      (irq_ack_i),
    .ovf      (ovf_w),
    .irq      (irq_o),
    .cnt      (cnt_w)
);

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] ext_cnt_i = '0;
    logic [1:0] gate_pin_i = '0;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic [1:0] irq_ack_i = '0;
    logic [1:0] irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr_pair dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .ext_cnt_i   (ext_cnt_i),
        .gate_pin_i  (gate_pin_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_ack_i   (irq_ack_i),
        .irq_o       (irq_o)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] n;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic       eflag;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd1, 8'h12, 8'h34, 8'd5, 8'h12, 8'h39, 1'b0},
        '{2'd1, 8'hFF, 8'hFE, 8'd3, 8'h00, 8'h01, 1'b1},
        '{2'd0, 8'h05, 8'hFE, 8'd3, 8'h06, 8'hE1, 1'b0},
        '{2'd0, 8'hFF, 8'h1F, 8'd1, 8'h00, 8'h00, 1'b1},
        '{2'd2, 8'hF0, 8'hFE, 8'd3, 8'hF0, 8'hF1, 1'b1},
        '{2'd2, 8'h80, 8'h10, 8'd4, 8'h80, 8'h14, 1'b0},
        '{2'd3, 8'h10, 8'hFF, 8'd2, 8'h12, 8'h01, 1'b1},
        '{2'd3, 8'hFE, 8'h00, 8'd2, 8'h00, 8'h02, 1'b1}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr_i = a;
        #2;
        v = reg_rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        string req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1", {8'h0, v}, 16'h0000);
        end
        chk("R1", {14'h0, irq_o}, 16'h0000);

        // R2 map and readback
        wr(0, 8'h5A);
        rd(0, v); chk("R2", {8'h0, v}, 16'h005A);
        wr(1, 8'hFF);
        rd(1, v); chk("R2", {8'h0, v}, 16'h000F);
        chk("R9", {14'h0, irq_o}, 16'h0003);
        rd(6, v); chk("R2", {8'h0, v}, 16'h0000);
        wr(1, 8'h00);

        // Vector table, channel 0 in timer mode
        for (int i = 0; i < 8; i++) begin
            case (VECS[i].mode)
                2'd0:    req = "R5";
                2'd1:    req = "R6";
                2'd2:    req = "R7";
                default: req = "R8";
            endcase
            wr(1, 8'h00);
            wr(0, {6'b0, VECS[i].mode});
            wr(2, VECS[i].lo);
            wr(3, VECS[i].hi);
            wr(1, 8'h01);
            ticks(int'(VECS[i].n));
            rd(2, v); chk(req, {8'h0, v}, {8'h0, VECS[i].elo});
            rd(3, v); chk(req, {8'h0, v}, {8'h0, VECS[i].ehi});
            rd(1, v); chk(req, {15'h0, v[1]}, {15'h0, VECS[i].eflag});
        end

        // R3 run bit clear blocks counting
        wr(1, 8'h00);
        wr(0, 8'h01);
        wr(2, 8'h00); wr(3, 8'h00);
        ticks(5);
        rd(2, v); chk("R3", {8'h0, v}, 16'h0000);

        // R3 gating, R10 independence
        wr(0, 8'h91);
        wr(4, 8'h00); wr(5, 8'h00);
        wr(1, 8'h05);
        gate_pin_i = 2'b00;
        ticks(4);
        rd(2, v); chk("R10", {8'h0, v}, 16'h0004);
        rd(4, v); chk("R3", {8'h0, v}, 16'h0000);
        @(negedge clk); gate_pin_i = 2'b10;
        ticks(3);
        rd(2, v); chk("R10", {8'h0, v}, 16'h0007);
        rd(4, v); chk("R3", {8'h0, v}, 16'h0003);
        gate_pin_i = 2'b00;

        // R4 counter source: falling edges sampled on ticks
        wr(1, 8'h00);
        wr(0, 8'h05);
        wr(2, 8'h00); wr(3, 8'h00);
        wr(1, 8'h01);
        @(negedge clk);
        tick_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ext_cnt_i[0] = 1'b1;
            repeat (2) @(negedge clk);
            ext_cnt_i[0] = 1'b0;
            repeat (2) @(negedge clk);
        end
        tick_i = 1'b0;
        rd(2, v); chk("R4", {8'h0, v}, 16'h0003);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ext_cnt_i[0] = 1'b1;
            @(negedge clk); ext_cnt_i[0] = 1'b0;
        end
        ticks(2);
        rd(2, v); chk("R4", {8'h0, v}, 16'h0003);

        // R9 acknowledge and software clear
        wr(0, 8'h01);
        wr(2, 8'hFF); wr(3, 8'hFF);
        ticks(1);
        chk("R9", {14'h0, irq_o}, 16'h0001);
        @(negedge clk); irq_ack_i = 2'b01;
        @(negedge clk); irq_ack_i = 2'b00;
        chk("R9", {14'h0, irq_o}, 16'h0000);
        wr(2, 8'hFF); wr(3, 8'hFF);
        ticks(1);
        chk("R9", {14'h0, irq_o}, 16'h0001);
        wr(1, 8'h01);
        chk("R9", {14'h0, irq_o}, 16'h0000);
        rd(1, v); chk("R9", {8'h0, v}, 16'h0001);

        // R9 overflow wins over acknowledge in the same cycle
        wr(2, 8'hFF); wr(3, 8'hFF);
        @(negedge clk); tick_i = 1'b1; irq_ack_i = 2'b01;
        @(negedge clk); tick_i = 1'b0; irq_ack_i = 2'b00;
        chk("R9", {14'h0, irq_o}, 16'h0001);

        finish_up();
    end
endmodule